// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a circular list of transmit descriptors kept in an on-chip memory. It reads each descriptor through a single-port memory interface. When software has handed a descriptor to hardware, the block passes the buffer address and frame length to a downstream frame sender. It waits for the sender to report completion, then writes the control word back with the ownership flag cleared. After that it moves to the next descriptor, or back to the ring base when the descriptor is flagged as the last one in the list.

Software loads a ring base address and pulses a start request. The request bit stays set while the fetcher works. The block clears it on its own as soon as it reads a descriptor that hardware does not own, and the fetch pointer then stays on that descriptor, so the next start resumes there. A descriptor with a zero length is handed back without a send and raises a sticky error flag. A soft reset pulse stops the engine at once and returns the pointer to the base.

Top module: `tx_ring_fetch`

## Requirements
- R1: After rst_ni is deasserted, run_o, err_o, mem_req_o and snd_valid_o are all 0, and the base and fetch pointer are both 0.
- R2: A base_we_i pulse loads both the ring base and the fetch pointer from base_wdata_i with bits 3:0 forced to zero, so descriptors are always aligned to their 16-byte size.
- R3: start_i sets run_o at the next clock edge. soft_rst_i takes priority over start_i in the same cycle.
- R4: A descriptor takes 16 bytes and is read word by word with one-cycle read latency, in the order +0, +4, +8. Word 0 carries the owned flag in bit 31, the end-of-list flag in bit 30 and the frame-position field in bits 29:28. Word 1 carries the frame length in bits 31:16. Word 2 carries the buffer address. Word 3 is unused.
- R5: For an owned descriptor with a nonzero length, snd_valid_o is raised with snd_addr_o and snd_len_o taken from the descriptor. These outputs hold steady until snd_ready_i is seen high.
- R6: After snd_done_i, word 0 is written back with bit 31 cleared and every other bit unchanged.
- R7: After a writeback, the pointer moves to the ring base if the end-of-list flag was set, and otherwise advances by 16 bytes.
- R8: Reading a word 0 with bit 31 clear makes run_o drop. In that case there is no send and no writeback, and the pointer stays on that descriptor.
- R9: An owned descriptor with length 0 is never sent. Its word 0 is written back with bit 31 cleared, the pointer advances, and err_o becomes 1 and stays 1 until rst_ni.
- R10: soft_rst_i clears run_o, abandons any descriptor in flight without writing it back, drops snd_valid_o and returns the pointer to the ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that sets the transmit request |
| soft_rst_i | input | 1 | Pulse that stops the engine and rewinds the pointer |
| base_we_i | input | 1 | Load strobe for the ring base |
| base_wdata_i | input | AW | Ring base byte address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid the cycle after a read request |
| snd_valid_o | output | 1 | Frame send request |
| snd_ready_i | input | 1 | Sender accepts the request |
| snd_addr_o | output | 32 | Buffer address of the frame |
| snd_len_o | output | 16 | Frame length |
| snd_done_i | input | 1 | Sender reports the frame is finished |
| run_o | output | 1 | Transmit request bit |
| err_o | output | 1 | Sticky zero-length error |

## Verification
The assertions check the following on every cycle:
- send outputs stay stable while the sender stalls;
- a zero length never reaches the sender;
- every writeback has the owned flag clear;
- err_o stays sticky;
- start sets the request bit;
- soft reset leaves the engine quiet on the next cycle.

Only the bench scenarios can show the ring-level behaviour. This covers the order of sends across a lap, wrap to the base at the end-of-list descriptor, resuming at the descriptor where the engine stopped, preservation of the other word 0 bits, and the pointer returning to base after a soft reset.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam int WORD_W     = 32;
  localparam int LEN_W      = 16;
  localparam int BIT_OWN    = 31;
  localparam int BIT_EOL    = 30;
  localparam int DESC_SHIFT = 4;
  localparam int DESC_BYTES = 1 << DESC_SHIFT;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_CAP0, S_RD1, S_CAP1, S_RD2, S_CAP2, S_SEND, S_WAIT, S_WB
  } fetch_state_e;
endpackage

// File: rtl/tx_ring_ptr.sv
module tx_ring_ptr
  import tx_ring_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_wdata_i,
  input  logic          soft_rst_i,
  input  logic          adv_i,
  input  logic          eol_i,
  output logic [AW-1:0] ptr_o
);
  localparam int LOW = DESC_SHIFT;
  localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);

  logic [AW-1:0] base_q, ptr_q;
  logic [AW-1:0] base_aligned;

  assign base_aligned = {base_wdata_i[AW-1:LOW], {LOW{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (base_we_i) begin
      base_q <= base_aligned;
      ptr_q  <= base_aligned;
    end else if (soft_rst_i) begin
      ptr_q  <= base_q;
    end else if (adv_i) begin
      ptr_q  <= eol_i ? base_q : ptr_q + STRIDE;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tx_ring_ctl.sv
module tx_ring_ctl
  import tx_ring_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              soft_rst_i,
  input  logic [AW-1:0]     ptr_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              snd_ready_i,
  input  logic              snd_done_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              snd_valid_o,
  output logic [WORD_W-1:0] snd_addr_o,
  output logic [LEN_W-1:0]  snd_len_o,
  output logic              run_o,
  output logic              err_o,
  output logic              adv_o,
  output logic              eol_o
);
  localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << BIT_OWN;

  fetch_state_e      state_q, state_d;
  logic [WORD_W-1:0] ctrl_q, baddr_q;
  logic [LEN_W-1:0]  len_q;
  logic              run_q, err_q;
  logic [1:0]        wsel;
  logic              req, we, adv;
  logic              own_seen, len_zero;

  assign own_seen = mem_rdata_i[BIT_OWN];
  assign len_zero = (mem_rdata_i[WORD_W-1 -: LEN_W] == '0);

  always_comb begin
    state_d = state_q;
    req     = 1'b0;
    we      = 1'b0;
    wsel    = 2'd0;
    adv     = 1'b0;
    unique case (state_q)
      S_IDLE: if (run_q) state_d = S_RD0;
      S_RD0:  begin req = 1'b1; wsel = 2'd0; state_d = S_CAP0; end
      S_CAP0: state_d = own_seen ? S_RD1 : S_IDLE;
      S_RD1:  begin req = 1'b1; wsel = 2'd1; state_d = S_CAP1; end
      S_CAP1: state_d = len_zero ? S_WB : S_RD2;
      S_RD2:  begin req = 1'b1; wsel = 2'd2; state_d = S_CAP2; end
      S_CAP2: state_d = S_SEND;
      S_SEND: if (snd_ready_i) state_d = S_WAIT;
      S_WAIT: if (snd_done_i) state_d = S_WB;
      S_WB:   begin req = 1'b1; we = 1'b1; adv = 1'b1; state_d = S_IDLE; end
      default: state_d = S_IDLE;
    endcase
    // soft reset abandons the descriptor in flight
    if (soft_rst_i) begin
      state_d = S_IDLE;
      req     = 1'b0;
      we      = 1'b0;
      adv     = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ctrl_q  <= '0;
      len_q   <= '0;
      baddr_q <= '0;
      run_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_CAP0) ctrl_q  <= mem_rdata_i;
      if (state_q == S_CAP1) len_q   <= mem_rdata_i[WORD_W-1 -: LEN_W];
      if (state_q == S_CAP2) baddr_q <= mem_rdata_i;
      if (soft_rst_i)                             run_q <= 1'b0;
      else if (start_i)                           run_q <= 1'b1;
      else if (state_q == S_CAP0 && !own_seen)    run_q <= 1'b0;
      if (state_q == S_CAP1 && len_zero && !soft_rst_i) err_q <= 1'b1;
    end
  end

  assign mem_req_o   = req;
  assign mem_we_o    = we;
  assign mem_addr_o  = ptr_i + AW'({wsel, 2'b00});
  assign mem_wdata_o = ctrl_q & ~OWN_MASK;
  assign snd_valid_o = (state_q == S_SEND);
  assign snd_addr_o  = baddr_q;
  assign snd_len_o   = len_q;
  assign run_o       = run_q;
  assign err_o       = err_q;
  assign adv_o       = adv;
  assign eol_o       = ctrl_q[BIT_EOL];
endmodule

// File: rtl/tx_ring_fetch.sv
module tx_ring_fetch
  import tx_ring_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              soft_rst_i,
  input  logic              base_we_i,
  input  logic [AW-1:0]     base_wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              snd_valid_o,
  input  logic              snd_ready_i,
  output logic [WORD_W-1:0] snd_addr_o,
  output logic [LEN_W-1:0]  snd_len_o,
  input  logic              snd_done_i,
  output logic              run_o,
  output logic              err_o
);
  logic [AW-1:0] ptr;
  logic          adv, eol;

  tx_ring_ptr #(.AW(AW)) i_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .base_we_i    (base_we_i),
    .base_wdata_i (base_wdata_i),
    .soft_rst_i   (soft_rst_i),
    .adv_i        (adv),
    .eol_i        (eol),
    .ptr_o        (ptr)
  );

  tx_ring_ctl #(.AW(AW)) i_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .soft_rst_i  (soft_rst_i),
    .ptr_i       (ptr),
    .mem_rdata_i (mem_rdata_i),
    .snd_ready_i (snd_ready_i),
    .snd_done_i  (snd_done_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .snd_valid_o (snd_valid_o),
    .snd_addr_o  (snd_addr_o),
    .snd_len_o   (snd_len_o),
    .run_o       (run_o),
    .err_o       (err_o),
    .adv_o       (adv),
    .eol_o       (eol)
  );
endmodule

// File: rtl/tx_ring_fetch_chk.sv
module tx_ring_fetch_chk #(
  parameter int AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          soft_rst_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          snd_valid_o,
  input logic          snd_ready_i,
  input logic [31:0]   snd_addr_o,
  input logic [15:0]   snd_len_o,
  input logic          run_o,
  input logic          err_o
);
  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !soft_rst_i |=> run_o);

  p_word_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00 && mem_addr_o[3:2] != 2'b11);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snd_valid_o && !snd_ready_i && !soft_rst_i |=>
      snd_valid_o && $stable(snd_addr_o) && $stable(snd_len_o));

  p_wb_own_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31] && mem_addr_o[3:0] == 4'h0);

  p_no_zero_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snd_valid_o |-> snd_len_o != 16'd0);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_soft_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !run_o && !snd_valid_o && !mem_req_o);
endmodule

bind tx_ring_fetch tx_ring_fetch_chk #(.AW(AW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .soft_rst_i  (soft_rst_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .snd_valid_o (snd_valid_o),
  .snd_ready_i (snd_ready_i),
  .snd_addr_o  (snd_addr_o),
  .snd_len_o   (snd_len_o),
  .run_o       (run_o),
  .err_o       (err_o)
);

// File: tb/test_tx_ring_fetch.sv
module test_tx_ring_fetch;
  localparam int AW = 12;
  localparam int MW = 1 << (AW - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start, srst, base_we;
  logic [AW-1:0] base_wd;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          snd_valid, snd_ready, snd_done;
  logic [31:0]   snd_addr;
  logic [15:0]   snd_len;
  logic          run, err;

  tx_ring_fetch #(.AW(AW)) i_tx_ring_fetch (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .soft_rst_i(srst),
    .base_we_i(base_we), .base_wdata_i(base_wd),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .snd_valid_o(snd_valid), .snd_ready_i(snd_ready), .snd_addr_o(snd_addr),
    .snd_len_o(snd_len), .snd_done_i(snd_done), .run_o(run), .err_o(err)
  );

  logic [31:0]   mem [MW];
  logic          tb_we;
  logic [AW-3:0] tb_a;
  logic [31:0]   tb_d;
  logic [7:0]    cyc;
  logic          rdy_force, hold;
  int            nsend;
  int            dcnt;
  logic [31:0]   log_a [64];
  logic [15:0]   log_l [64];
  int            nchk = 0;
  int            nerr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MW; i++) mem[i] <= '0;
      mem_rdata <= '0;
    end else begin
      if (tb_we) mem[tb_a] <= tb_d;
      else if (mem_req && mem_we) mem[mem_addr[AW-1:2]] <= mem_wdata;
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[AW-1:2]];
    end
  end

  assign snd_ready = !hold && (rdy_force || cyc[1]);

  always @(posedge clk) begin
    cyc      <= cyc + 8'd1;
    snd_done <= 1'b0;
    if (!rst_n) begin
      nsend <= 0;
      dcnt  <= 0;
    end else if (snd_valid && snd_ready) begin
      log_a[nsend & 63] <= snd_addr;
      log_l[nsend & 63] <= snd_len;
      nsend <= nsend + 1;
      dcnt  <= 3;
    end else if (dcnt != 0) begin
      dcnt <= dcnt - 1;
      if (dcnt == 1) snd_done <= 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_word(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_a = a[AW-1:2]; tb_d = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  function automatic logic [31:0] w0(input logic own, input logic eol);
    return {own, eol, 2'b11, 28'h0};
  endfunction

  task automatic put_desc(input int base, input int idx, input logic own, input logic eol,
                          input logic [15:0] len, input logic [31:0] ba);
    logic [AW-1:0] a;
    a = AW'(base + idx * 16);
    put_word(a, w0(own, eol));
    put_word(a + AW'(4), {len, 16'h0});
    put_word(a + AW'(8), ba);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_srst();
    @(negedge clk); srst = 1'b1;
    @(negedge clk); srst = 1'b0;
  endtask

  task automatic write_base(input logic [AW-1:0] b);
    @(negedge clk); base_we = 1'b1; base_wd = b;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic run_wait(input string tag);
    int n;
    pulse_start();
    n = 0;
    while (run && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk({tag, " stop timeout"}, 32'd1, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_len(input int n, input int k);
    return 16'(60 + n * 7 + k);
  endfunction

  function automatic logic [31:0] exp_ba(input int n, input int k);
    return 32'h8000_0000 + 32'(n) * 32'h1000 + 32'(k) * 32'h40;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int s0;
    start = 0; srst = 0; base_we = 0; base_wd = '0;
    tb_we = 0; tb_a = '0; tb_d = '0; cyc = '0; rdy_force = 1; hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 run_o", 32'(run), 0);
    chk("R1 err_o", 32'(err), 0);
    chk("R1 mem_req_o", 32'(mem_req), 0);
    chk("R1 snd_valid_o", 32'(snd_valid), 0);

    // R3: soft reset beats start in the same cycle
    @(negedge clk); start = 1; srst = 1;
    @(negedge clk); start = 0; srst = 0;
    chk("R3 srst priority", 32'(run), 0);

    // ring sweep: sizes 1..4, two laps each (R4 R5 R6 R7)
    for (int n = 1; n <= 4; n++) begin
      rdy_force = n[0];
      write_base(AW'(n * 256));
      for (int lap = 0; lap < 2; lap++) begin
        for (int k = 0; k < n; k++)
          put_desc(n * 256, k, 1'b1, k == n - 1, exp_len(n, k), exp_ba(n, k));
        s0 = nsend;
        run_wait("R7 lap");
        chk("R5 send count", 32'(nsend - s0), 32'(n));
        for (int k = 0; k < n; k++) begin
          chk("R5 snd_addr_o", log_a[(s0 + k) & 63], exp_ba(n, k));
          chk("R4 snd_len_o", 32'(log_l[(s0 + k) & 63]), 32'(exp_len(n, k)));
          chk("R6 word0 writeback", mem[(n * 256 + k * 16) >> 2], w0(1'b0, k == n - 1));
        end
      end
    end
    rdy_force = 1;

    // R8: base 0x400, pointer back at desc0, nothing owned
    s0 = nsend;
    pulse_start();
    chk("R3 run_o set", 32'(run), 1);
    repeat (6) @(negedge clk);
    chk("R8 run_o cleared", 32'(run), 0);
    chk("R8 no send", 32'(nsend - s0), 0);
    chk("R8 word0 untouched", mem[1024 >> 2], w0(1'b0, 1'b0));
    put_desc(1024, 0, 1'b1, 1'b0, 16'd21, 32'h1234_0000);
    s0 = nsend;
    run_wait("R8 resume");
    chk("R8 resumes at same desc", 32'(nsend - s0), 1);
    chk("R8 resume addr", log_a[s0 & 63], 32'h1234_0000);

    // R9: zero length at desc1, valid desc2
    chk("R9 err_o before", 32'(err), 0);
    put_desc(1024, 1, 1'b1, 1'b0, 16'd0, 32'hDEAD_0000);
    put_desc(1024, 2, 1'b1, 1'b0, 16'd77, 32'h5555_0040);
    s0 = nsend;
    run_wait("R9");
    chk("R9 only valid desc sent", 32'(nsend - s0), 1);
    chk("R9 sent len", 32'(log_l[s0 & 63]), 77);
    chk("R9 err_o set", 32'(err), 1);
    chk("R9 zero desc returned", mem[(1024 + 16) >> 2], w0(1'b0, 1'b0));

    // R10: soft reset while the send is stalled at desc3
    put_desc(1024, 3, 1'b1, 1'b1, 16'd90, 32'h7777_0000);
    hold = 1;
    s0 = nsend;
    pulse_start();
    for (int i = 0; i < 40 && !snd_valid; i++) @(negedge clk);
    chk("R5 valid under stall", 32'(snd_valid), 1);
    pulse_srst();
    chk("R10 run_o cleared", 32'(run), 0);
    chk("R10 snd_valid_o dropped", 32'(snd_valid), 0);
    hold = 0;
    repeat (8) @(negedge clk);
    chk("R10 no send", 32'(nsend - s0), 0);
    chk("R10 no writeback", mem[(1024 + 48) >> 2], w0(1'b1, 1'b1));
    chk("R9 err_o sticky", 32'(err), 1);
    put_desc(1024, 0, 1'b1, 1'b0, 16'd33, 32'h3333_0000);
    s0 = nsend;
    run_wait("R10 rewind");
    chk("R10 pointer at base", 32'(nsend - s0), 1);
    chk("R10 base desc sent", log_a[s0 & 63], 32'h3333_0000);

    // R2: unaligned base write lands on 0x200
    write_base(AW'(12'h20D));
    put_desc(512, 0, 1'b1, 1'b1, 16'd44, 32'h4444_0000);
    s0 = nsend;
    run_wait("R2");
    chk("R2 aligned base send", 32'(nsend - s0), 1);
    chk("R2 aligned base len", 32'(log_l[s0 & 63]), 44);
    chk("R2 word0 at aligned base", mem[512 >> 2], w0(1'b0, 1'b1));

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule